// File: doc/BRIEF.md
# Camera PHY Receiver Bring-Up Sequencer

This block brings a camera PHY receiver into service when a start-stream request arrives. It takes a lane count and a link frequency in Mbps. It doubles the frequency to get the per-lane data rate and looks up a frequency-band code. It then programs the per-lane control fields and pulses the receiver's test-clear line. Finally, it sends a fixed series of internal register writes through a command master port that uses a valid/ready/done handshake.

A streaming flag records that bring-up has finished. While the flag is set, a further start request does nothing. A stop request only clears the flag and leaves every field as it was. A start request with a bad lane count or a zero frequency raises a one-cycle error pulse and changes nothing.

Top module: `rxphy_bringup`

## Requirements
- R1: After reset, `streaming`, `busy`, `cmd_valid`, `test_clr` and `cfg_err` are 0, and every lane control field is 0.
- R2: The band code is looked up from the data rate, which is twice `link_freq`. The table is searched from the lowest upper bound upwards, and the first entry whose bound is at least the rate supplies the code. The table entries are written as bound:code, with codes in decimal: 89:0, 99:16, 109:32, 129:1, 139:17, 149:33, 169:2, 179:18, 199:34, 219:3, 239:19, 249:35, 269:4, 299:20, 329:5, 359:21, 399:37, 449:6, 499:22, 549:7, 599:23, 649:8, 699:24, 749:9, 799:25, 849:41, 899:57, 949:10, 999:26, 1049:42, 1099:58, 1149:11, 1199:27, 1249:43, 1299:59, 1349:12, 1399:28, 1449:44, 1500:60.
- R3: If the data rate is above 1500, the band code is 0.
- R4: An accepted start sets `force_rx`, `force_stop` and `turn_req` to 0 and `turn_dis` to all ones. It sets `lane_en` to a mask of the low N bits for a lane count N from 1 to 4.
- R5: A start request with a lane count of 0 or above 4, or with a `link_freq` of 0, gives one cycle of `cfg_err`. It issues no command, does not raise `busy` and leaves all fields unchanged.
- R6: `test_clr` stays high for exactly CLR_CYCLES cycles after the start is accepted. It then stays low for at least CLR_CYCLES cycles before the first command is issued.
- R7: Exactly seven commands are issued, as (code, data) pairs in this order: (0x34, 0), (0x44, band code shifted left by one), (0x54, 0), (0x84, 0), (0x94, 0), (0x75, 4), (0x00, 0).
- R8: `cmd_valid` stays high, with `cmd_code` and `cmd_data` unchanged, until `cmd_ready` is seen. No new command is issued before `cmd_done` has been seen for the current one.
- R9: `streaming` rises in the same cycle that `busy` falls, after the `cmd_done` of the seventh command, and never earlier.
- R10: A start request while `streaming` is high issues no command and changes no field.
- R11: `stop_req` clears `streaming` at the next edge. If it coincides with the final `cmd_done`, the stop wins and `streaming` stays 0.
- R12: A start request while `busy` is high is ignored. The sequence in progress keeps its own lane mask and band code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Start-stream request, one cycle |
| stop_req | input | 1 | Stop-stream request, one cycle |
| lane_cnt | input | $clog2(LANES+1) | Number of data lanes to enable |
| link_freq | input | FREQ_W | Link frequency in Mbps |
| lane_en | output | LANES | Lane enable mask |
| force_rx | output | LANES | Force-receive control per lane |
| force_stop | output | LANES | Force-stop-state control per lane |
| turn_req | output | LANES | Turnaround request per lane |
| turn_dis | output | LANES | Turnaround disable per lane |
| test_clr | output | 1 | Test-interface clear pulse to the receiver |
| cmd_valid | output | 1 | Command request valid |
| cmd_code | output | 8 | Internal register code |
| cmd_data | output | 8 | Internal register data |
| cmd_ready | input | 1 | Command accepted by the master |
| cmd_done | input | 1 | Command completed by the master |
| busy | output | 1 | Bring-up sequence in progress |
| streaming | output | 1 | Bring-up complete and stream active |
| cfg_err | output | 1 | Rejected start request, one cycle |

## Verification
The completion `cmd_done` of the seventh command can land in the same cycle as a `stop_req`. In that cycle the flag is being set and cleared at once. The bench provokes this by having its command responder raise the stop line together with the last done pulse. It then judges the outcome at the ports: `busy` must have fallen and `streaming` must still be 0.

A second overlap is a start request that arrives while a sequence is running. The bench checks that it leaves the running sequence's lane mask and band code in place.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  localparam int NUM_STEPS = 7;
  localparam int STEP_W    = 3;
  localparam int RATE_W    = 16;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CLR_HI, SQ_CLR_LO, SQ_ISSUE, SQ_WAIT
  } seq_st_t;

  typedef enum logic [1:0] {
    CP_IDLE, CP_REQ, CP_WAIT
  } cp_st_t;

  // ascending upper bounds; the first bound >= rate selects the band
  function automatic logic [7:0] band_of_rate(input logic [RATE_W-1:0] r);
    logic [7:0] c;
    if      (r <= 16'd89)   c = 8'h00;
    else if (r <= 16'd99)   c = 8'h10;
    else if (r <= 16'd109)  c = 8'h20;
    else if (r <= 16'd129)  c = 8'h01;
    else if (r <= 16'd139)  c = 8'h11;
    else if (r <= 16'd149)  c = 8'h21;
    else if (r <= 16'd169)  c = 8'h02;
    else if (r <= 16'd179)  c = 8'h12;
    else if (r <= 16'd199)  c = 8'h22;
    else if (r <= 16'd219)  c = 8'h03;
    else if (r <= 16'd239)  c = 8'h13;
    else if (r <= 16'd249)  c = 8'h23;
    else if (r <= 16'd269)  c = 8'h04;
    else if (r <= 16'd299)  c = 8'h14;
    else if (r <= 16'd329)  c = 8'h05;
    else if (r <= 16'd359)  c = 8'h15;
    else if (r <= 16'd399)  c = 8'h25;
    else if (r <= 16'd449)  c = 8'h06;
    else if (r <= 16'd499)  c = 8'h16;
    else if (r <= 16'd549)  c = 8'h07;
    else if (r <= 16'd599)  c = 8'h17;
    else if (r <= 16'd649)  c = 8'h08;
    else if (r <= 16'd699)  c = 8'h18;
    else if (r <= 16'd749)  c = 8'h09;
    else if (r <= 16'd799)  c = 8'h19;
    else if (r <= 16'd849)  c = 8'h29;
    else if (r <= 16'd899)  c = 8'h39;
    else if (r <= 16'd949)  c = 8'h0a;
    else if (r <= 16'd999)  c = 8'h1a;
    else if (r <= 16'd1049) c = 8'h2a;
    else if (r <= 16'd1099) c = 8'h3a;
    else if (r <= 16'd1149) c = 8'h0b;
    else if (r <= 16'd1199) c = 8'h1b;
    else if (r <= 16'd1249) c = 8'h2b;
    else if (r <= 16'd1299) c = 8'h3b;
    else if (r <= 16'd1349) c = 8'h0c;
    else if (r <= 16'd1399) c = 8'h1c;
    else if (r <= 16'd1449) c = 8'h2c;
    else if (r <= 16'd1500) c = 8'h3c;
    else                    c = 8'h00;
    return c;
  endfunction

  function automatic logic [7:0] step_code(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    return 8'h34;
      3'd1:    return 8'h44;
      3'd2:    return 8'h54;
      3'd3:    return 8'h84;
      3'd4:    return 8'h94;
      3'd5:    return 8'h75;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] step_data(input logic [STEP_W-1:0] idx,
                                           input logic [7:0] band);
    case (idx)
      3'd1:    return {band[6:0], 1'b0};
      3'd5:    return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rxb_band_lookup.sv
module rxb_band_lookup
  import rxb_pkg::*;
#(
  parameter int FREQ_W = 11
) (
  input  logic [FREQ_W-1:0] link_freq,
  output logic [7:0]        band
);
  logic [FREQ_W:0]   rate;
  logic [RATE_W-1:0] rate_ext;

  assign rate     = {link_freq, 1'b0};
  assign rate_ext = RATE_W'(rate);
  assign band     = band_of_rate(rate_ext);
endmodule

// File: rtl/rxb_cmd_port.sv
module rxb_cmd_port
  import rxb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic [7:0] code_in,
  input  logic [7:0] data_in,
  input  logic       cmd_ready,
  input  logic       cmd_done,
  output logic       cmd_valid,
  output logic [7:0] cmd_code,
  output logic [7:0] cmd_data,
  output logic       xfer_done,
  output logic       waiting
);
  cp_st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= CP_IDLE;
      cmd_code <= '0;
      cmd_data <= '0;
    end else begin
      case (st)
        CP_IDLE: if (issue) begin
          cmd_code <= code_in;
          cmd_data <= data_in;
          st       <= CP_REQ;
        end
        CP_REQ:  if (cmd_ready) st <= cmd_done ? CP_IDLE : CP_WAIT;
        CP_WAIT: if (cmd_done)  st <= CP_IDLE;
        default: st <= CP_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st == CP_REQ);
  assign waiting   = (st == CP_WAIT);
  assign xfer_done = ((st == CP_WAIT) && cmd_done) ||
                     ((st == CP_REQ) && cmd_ready && cmd_done);
endmodule

// File: rtl/rxb_seq_ctrl.sv
module rxb_seq_ctrl
  import rxb_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int CLR_CYCLES = 8,
  localparam int LC_W      = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic [LC_W-1:0]  lane_cnt,
  input  logic             freq_zero,
  input  logic [7:0]       band_in,
  input  logic             xfer_done,
  output logic             issue,
  output logic [7:0]       code_out,
  output logic [7:0]       data_out,
  output logic             test_clr,
  output logic             busy,
  output logic             streaming,
  output logic             cfg_err,
  output logic             last_done,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] force_rx,
  output logic [LANES-1:0] force_stop,
  output logic [LANES-1:0] turn_req,
  output logic [LANES-1:0] turn_dis
);
  localparam int CNT_W = $clog2(CLR_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(CLR_CYCLES - 1);
  localparam logic [STEP_W-1:0] IDX_LAST = STEP_W'(NUM_STEPS - 1);

  function automatic logic [LANES-1:0] mask_of(input logic [LC_W-1:0] n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  seq_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] idx;
  logic [7:0]        band_q;
  logic              lanes_ok, start_ok, accept, reject;

  assign lanes_ok  = (lane_cnt != '0) && (int'(lane_cnt) <= LANES);
  assign start_ok  = start_req && (st == SQ_IDLE) && !streaming;
  assign accept    = start_ok && lanes_ok && !freq_zero;
  assign reject    = start_ok && !accept;
  assign last_done = (st == SQ_WAIT) && xfer_done && (idx == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      cnt        <= '0;
      idx        <= '0;
      band_q     <= '0;
      streaming  <= 1'b0;
      cfg_err    <= 1'b0;
      lane_en    <= '0;
      force_rx   <= '0;
      force_stop <= '0;
      turn_req   <= '0;
      turn_dis   <= '0;
    end else begin
      cfg_err <= reject;
      if (stop_req)       streaming <= 1'b0;
      else if (last_done) streaming <= 1'b1;
      case (st)
        SQ_IDLE: if (accept) begin
          band_q     <= band_in;
          lane_en    <= mask_of(lane_cnt);
          force_rx   <= '0;
          force_stop <= '0;
          turn_req   <= '0;
          turn_dis   <= '1;
          cnt        <= '0;
          st         <= SQ_CLR_HI;
        end
        SQ_CLR_HI: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            st  <= SQ_CLR_LO;
          end else cnt <= cnt + 1'b1;
        end
        SQ_CLR_LO: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            idx <= '0;
            st  <= SQ_ISSUE;
          end else cnt <= cnt + 1'b1;
        end
        SQ_ISSUE: st <= SQ_WAIT;
        SQ_WAIT: if (xfer_done) begin
          if (idx == IDX_LAST) st <= SQ_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= SQ_ISSUE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign issue    = (st == SQ_ISSUE);
  assign code_out = step_code(idx);
  assign data_out = step_data(idx, band_q);
  assign test_clr = (st == SQ_CLR_HI);
  assign busy     = (st != SQ_IDLE);
endmodule

// File: rtl/rxphy_bringup.sv
module rxphy_bringup
  import rxb_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int FREQ_W     = 11,
  parameter int CLR_CYCLES = 8,
  localparam int LC_W      = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic [LC_W-1:0]   lane_cnt,
  input  logic [FREQ_W-1:0] link_freq,
  output logic [LANES-1:0]  lane_en,
  output logic [LANES-1:0]  force_rx,
  output logic [LANES-1:0]  force_stop,
  output logic [LANES-1:0]  turn_req,
  output logic [LANES-1:0]  turn_dis,
  output logic              test_clr,
  output logic              cmd_valid,
  output logic [7:0]        cmd_code,
  output logic [7:0]        cmd_data,
  input  logic              cmd_ready,
  input  logic              cmd_done,
  output logic              busy,
  output logic              streaming,
  output logic              cfg_err
);
  logic [7:0] band;
  logic [7:0] seq_code, seq_data;
  logic       seq_issue, xfer_done, cp_waiting, last_done;

  rxb_band_lookup #(.FREQ_W(FREQ_W)) u_lookup (
    .link_freq (link_freq),
    .band      (band)
  );

  rxb_seq_ctrl #(.LANES(LANES), .CLR_CYCLES(CLR_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .lane_cnt   (lane_cnt),
    .freq_zero  (link_freq == '0),
    .band_in    (band),
    .xfer_done  (xfer_done),
    .issue      (seq_issue),
    .code_out   (seq_code),
    .data_out   (seq_data),
    .test_clr   (test_clr),
    .busy       (busy),
    .streaming  (streaming),
    .cfg_err    (cfg_err),
    .last_done  (last_done),
    .lane_en    (lane_en),
    .force_rx   (force_rx),
    .force_stop (force_stop),
    .turn_req   (turn_req),
    .turn_dis   (turn_dis)
  );

  rxb_cmd_port u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (seq_issue),
    .code_in   (seq_code),
    .data_in   (seq_data),
    .cmd_ready (cmd_ready),
    .cmd_done  (cmd_done),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_data  (cmd_data),
    .xfer_done (xfer_done),
    .waiting   (cp_waiting)
  );
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic [LANES-1:0] lane_en,
  input logic             test_clr,
  input logic             cmd_valid,
  input logic [7:0]       cmd_code,
  input logic [7:0]       cmd_data,
  input logic             cmd_ready,
  input logic             busy,
  input logic             streaming,
  input logic             cfg_err,
  input logic             seq_issue,
  input logic             cp_waiting
);
  p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_data));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_issue |-> !cmd_valid && !cp_waiting);

  p_stream_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    streaming |-> !cmd_valid && !test_clr);

  p_stream_after_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(streaming) |-> $fell(busy));

  p_reject_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !cmd_valid);

  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !streaming);

  p_clr_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    test_clr |-> busy && !cmd_valid);

  p_lane_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en & LANES'(lane_en + 1'b1)) == '0);
endmodule

bind rxphy_bringup rxb_checker #(.LANES(LANES)) u_rxb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_req   (stop_req),
  .lane_en    (lane_en),
  .test_clr   (test_clr),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .cmd_data   (cmd_data),
  .cmd_ready  (cmd_ready),
  .busy       (busy),
  .streaming  (streaming),
  .cfg_err    (cfg_err),
  .seq_issue  (seq_issue),
  .cp_waiting (cp_waiting)
);

// File: tb/test_rxphy_bringup.sv
module test_rxphy_bringup;
  localparam int LANES  = 4;
  localparam int FREQ_W = 11;
  localparam int CLR    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_drv = 1'b0, stop_drv = 1'b0, collide_stop = 1'b0;
  logic start_req, stop_req;
  logic [2:0] lane_cnt = '0;
  logic [FREQ_W-1:0] link_freq = '0;
  logic [LANES-1:0] lane_en, force_rx, force_stop, turn_req, turn_dis;
  logic test_clr, cmd_valid, busy, streaming, cfg_err;
  logic [7:0] cmd_code, cmd_data;
  logic cmd_ready = 1'b0, cmd_done = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit collide_arm = 0;
  int log_n = 0;
  int log_code[16];
  int log_data[16];
  int resp_k = 0;

  int bnd[39] = '{89, 99, 109, 129, 139, 149, 169, 179, 199, 219, 239, 249, 269,
                  299, 329, 359, 399, 449, 499, 549, 599, 649, 699, 749, 799, 849,
                  899, 949, 999, 1049, 1099, 1149, 1199, 1249, 1299, 1349, 1399,
                  1449, 1500};
  int cod[39] = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03,
                  'h13, 'h23, 'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07,
                  'h17, 'h08, 'h18, 'h09, 'h19, 'h29, 'h39, 'h0a, 'h1a, 'h2a,
                  'h3a, 'h0b, 'h1b, 'h2b, 'h3b, 'h0c, 'h1c, 'h2c, 'h3c};
  int exp_addr[7] = '{'h34, 'h44, 'h54, 'h84, 'h94, 'h75, 'h00};

  assign start_req = start_drv;
  assign stop_req  = stop_drv | collide_stop;

  always #2 clk = ~clk;

  rxphy_bringup #(.LANES(LANES), .FREQ_W(FREQ_W), .CLR_CYCLES(CLR)) i_rxphy_bringup (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .lane_cnt(lane_cnt), .link_freq(link_freq), .lane_en(lane_en),
    .force_rx(force_rx), .force_stop(force_stop), .turn_req(turn_req),
    .turn_dis(turn_dis), .test_clr(test_clr), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .cmd_done(cmd_done), .busy(busy), .streaming(streaming), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_band(input int freq);
    int rate = 2 * freq;
    for (int i = 0; i < 39; i++) if (bnd[i] >= rate) return cod[i];
    return 0;
  endfunction

  function automatic int exp_mask(input int n);
    return (1 << n) - 1;
  endfunction

  // command responder with varying ready/done latency
  initial begin
    int c, d, rd, dd;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        c = cmd_code; d = cmd_data;
        if (log_n < 16) begin log_code[log_n] = c; log_data[log_n] = d; end
        log_n++;
        rd = resp_k % 3; dd = 1 + (resp_k % 2); resp_k++;
        repeat (rd) begin
          @(negedge clk);
          check(cmd_valid && cmd_code == c && cmd_data == d, "R8 hold", cmd_code, c);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        repeat (dd) begin
          check(!cmd_valid, "R8 issue before done", cmd_valid, 0);
          @(negedge clk);
        end
        cmd_done = 1'b1;
        if (collide_arm && log_n == 7) collide_stop = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        collide_stop = 1'b0;
      end
    end
  end

  task automatic run(input int lanes, input int freq, input bit collide, input bit keep);
    int hi, lo, t, code;
    code = exp_band(freq);
    collide_arm = collide;
    log_n = 0;
    lane_cnt = 3'(lanes);
    link_freq = FREQ_W'(freq);
    start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    hi = 0;
    while (test_clr && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (!cmd_valid && lo < 100) begin lo++; @(negedge clk); end
    t = 0;
    while (busy && t < 2000) begin
      t++;
      if (streaming) check(0, "R9 early streaming", 1, 0);
      @(negedge clk);
    end
    check(hi == CLR, "R6 clear width", hi, CLR);
    check(lo >= CLR, "R6 clear gap", lo, CLR);
    check(log_n == 7, "R7 command count", log_n, 7);
    for (int i = 0; i < 7 && i < log_n; i++) begin
      check(log_code[i] == exp_addr[i], "R7 code", log_code[i], exp_addr[i]);
      if (i == 1) check(log_data[i] == 2 * code, "R2 R3 band data", log_data[i], 2 * code);
      else check(log_data[i] == (i == 5 ? 4 : 0), "R7 data", log_data[i], (i == 5 ? 4 : 0));
    end
    check(lane_en == LANES'(exp_mask(lanes)), "R4 lane mask", lane_en, exp_mask(lanes));
    check(turn_dis == '1 && force_rx == '0 && force_stop == '0 && turn_req == '0,
          "R4 lane fields", {turn_dis, force_rx, force_stop, turn_req}, 'hF000);
    check(streaming == !collide, "R9 R11 streaming at end", streaming, !collide);
    if (streaming && !keep) begin
      stop_drv = 1'b1;
      @(negedge clk);
      stop_drv = 1'b0;
      check(!streaming, "R11 stop clears", streaming, 0);
    end
  endtask

  task automatic reject_case(input int lanes, input int freq);
    bit saw_busy;
    log_n = 0;
    lane_cnt = 3'(lanes);
    link_freq = FREQ_W'(freq);
    start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    check(cfg_err == 1'b1, "R5 error pulse", cfg_err, 1);
    saw_busy = 0;
    repeat (20) begin
      @(negedge clk);
      if (busy) saw_busy = 1;
    end
    check(!saw_busy && log_n == 0, "R5 no sequence", log_n, 0);
    check(lane_en == 4'h3 && !cfg_err, "R5 fields kept", lane_en, 3);
  endtask

  initial begin
    bit saw_busy;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!streaming && !busy && !cmd_valid && !test_clr && !cfg_err, "R1 controls",
          {streaming, busy, cmd_valid, test_clr, cfg_err}, 0);
    check(lane_en == '0 && turn_dis == '0 && force_rx == '0 && force_stop == '0 && turn_req == '0,
          "R1 fields", lane_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R7: sweep of every even rate up to above the top bound
    for (int f = 1; f <= 760; f++) run(1 + (f % 4), f, 0, 0);
    run(4, 1023, 0, 0);
    run(2, 2047, 0, 0);

    // R10: start while streaming
    run(2, 100, 0, 1);
    log_n = 0;
    lane_cnt = 3'd4; link_freq = 11'd200;
    start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    saw_busy = 0;
    repeat (40) begin
      if (busy) saw_busy = 1;
      @(negedge clk);
    end
    check(!saw_busy && log_n == 0, "R10 no commands", log_n, 0);
    check(lane_en == 4'h3 && streaming, "R10 fields kept", lane_en, 3);
    stop_drv = 1'b1;
    @(negedge clk);
    stop_drv = 1'b0;
    check(!streaming && lane_en == 4'h3, "R11 stop only clears flag", lane_en, 3);

    // R5 rejected starts
    reject_case(0, 100);
    reject_case(5, 100);
    reject_case(7, 300);
    reject_case(2, 0);

    // R12 start while busy
    log_n = 0;
    lane_cnt = 3'd1; link_freq = 11'd300;
    start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    @(negedge clk);
    lane_cnt = 3'd4; link_freq = 11'd100;
    start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    for (int t = 0; t < 2000 && busy; t++) @(negedge clk);
    check(lane_en == 4'h1, "R12 mask kept", lane_en, 1);
    check(log_n == 7, "R12 single sequence", log_n, 7);
    check(log_data[1] == 2 * exp_band(300), "R12 band kept", log_data[1], 2 * exp_band(300));
    stop_drv = 1'b1;
    @(negedge clk);
    stop_drv = 1'b0;

    // R11 stop coinciding with the final done
    run(3, 400, 1, 0);
    check(!busy && !streaming, "R11 collision stop wins", streaming, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule